// File: doc/BRIEF.md
# Key Wake-Up Interrupt Port

This block is an eight-pin general-purpose port with key-press interrupt logic. Each pin has an output latch and a direction bit. When a pin is set as an output, its latch value drives it. When a pin is set as an input, its level passes through a synchronizer. Software programs four configuration registers through a single-cycle write interface: the latch, the direction, the key enables and the pull-ups. Pull-up control is kept per group: one pull-up register bit covers a group of adjacent pins.

A pin takes part in key detection only when it is an input and its key-enable bit is set. The block takes the AND of the synchronized levels of all participating pins. Pins that do not take part count as 1 in that AND. A one-cycle interrupt request is raised when the AND falls from 1 to 0, so one request marks the first key going down. Further keys pressed while the AND is already low raise no new request.

In the usual key-matrix setup, the lower nibble is set as key inputs with pull-ups. The upper nibble is set as outputs driving low, which scans an active-low matrix. Port reads return the synchronized level on input pins and the latch value on output pins.

Top module: `keywake_port`

## Requirements
- R1: After reset, pin_oe, pin_out, pin_pu and key_irq are all 0. The synchronizer holds all ones, so port_rd reads 0xFF while all pins are held high.
- R2: A write with wr_en high takes effect at the clock edge that samples it. Address 0 writes the output latch (seen on pin_out), address 1 writes the direction register (seen on pin_oe, where 1 means output), address 2 writes the key-enable register and address 3 writes the pull-up register.
- R3: Pull-up register bit g drives pin_pu for pins g*PU_GROUP through g*PU_GROUP+PU_GROUP-1. Written data bits at or above WIDTH/PU_GROUP are ignored.
- R4: For each pin, port_rd returns the latch bit when the pin is an output. When the pin is an input, port_rd returns the pin level delayed by SYNC_STAGES clock edges.
- R5: An input pin whose key-enable bit is 0 never raises a request, whatever its level.
- R6: When a participating pin falls while all participating pins are high, key_irq is high for exactly one cycle. That cycle follows the (SYNC_STAGES+1)-th rising edge after the pin change.
- R7: While any participating pin stays low, further participating pins going low raise no request. Once all of them are high again, a new press raises a new request.
- R8: Removing a low pin from participation raises no request. Adding a low pin to participation while the AND was 1 raises a request one edge after the write.
- R9: An output pin never takes part, even with its key-enable bit set and its pin_in held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 latch, 1 direction, 2 key enable, 3 pull-up |
| wr_data | input | WIDTH | Write data |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| pin_out | output | WIDTH | Pad output values from the latch |
| pin_oe | output | WIDTH | Pad output enables (1 means output) |
| pin_pu | output | WIDTH | Per-pin pull-up enables |
| port_rd | output | WIDTH | Port read value |
| key_irq | output | 1 | One-cycle key interrupt request |

## Verification
The bench builds the block with its defaults: WIDTH of 8, PU_GROUP of 4 and SYNC_STAGES of 2. This gives two pull-up groups, so the lower and upper nibbles can each be checked alone, and the out-of-range pull-up data bits can be checked as ignored. The nibble split also lets the key-matrix arrangement be built directly, with output and input pins side by side. The two-stage synchronizer fixes the request latency at three edges, which the bench checks cycle by cycle, together with the read latency of two edges.

// File: rtl/kw_pkg.sv
`timescale 1ns/1ps
package kw_pkg;
   localparam int KW_AW = 2;

   typedef enum logic [KW_AW-1:0] {
      KW_LATCH = 2'd0,
      KW_DIR   = 2'd1,
      KW_KEYEN = 2'd2,
      KW_PULL  = 2'd3
   } kw_reg_e;
endpackage

// File: rtl/kw_regs.sv
`timescale 1ns/1ps
module kw_regs #(
   parameter int WIDTH    = 8,
   parameter int PU_GROUP = 4,
   localparam int NPU     = WIDTH / PU_GROUP
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [kw_pkg::KW_AW-1:0] wr_addr,
   input  logic [WIDTH-1:0]        wr_data,
   output logic [WIDTH-1:0]        latch_q,
   output logic [WIDTH-1:0]        dir_q,
   output logic [WIDTH-1:0]        keyen_q,
   output logic [NPU-1:0]          pull_q
);
   import kw_pkg::*;

   logic sel_latch, sel_dir, sel_keyen, sel_pull;

   always_comb begin
      sel_latch = wr_en && (wr_addr == KW_LATCH);
      sel_dir   = wr_en && (wr_addr == KW_DIR);
      sel_keyen = wr_en && (wr_addr == KW_KEYEN);
      sel_pull  = wr_en && (wr_addr == KW_PULL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         keyen_q <= '0;
         pull_q  <= '0;
      end else begin
         if (sel_latch) latch_q <= wr_data;
         if (sel_dir)   dir_q   <= wr_data;
         if (sel_keyen) keyen_q <= wr_data;
         if (sel_pull)  pull_q  <= wr_data[NPU-1:0];
      end
   end
endmodule

// File: rtl/kw_sync.sv
`timescale 1ns/1ps
module kw_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   // Reset to all ones: an idle pulled-up pin reads high, so release
   // from reset cannot fake a falling edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '1;
      else        stage_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '1;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kw_keydet.sv
`timescale 1ns/1ps
module kw_keydet #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] part,
   output logic             irq
);
   logic and_now;
   logic and_q;

   // Pins outside the participating set count as 1.
   always_comb and_now = &(level | ~part);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         and_q <= 1'b1;
         irq   <= 1'b0;
      end else begin
         and_q <= and_now;
         irq   <= and_q & ~and_now;
      end
   end
endmodule

// File: rtl/keywake_port.sv
`timescale 1ns/1ps
module keywake_port #(
   parameter int WIDTH       = 8,
   parameter int PU_GROUP    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [kw_pkg::KW_AW-1:0] wr_addr,
   input  logic [WIDTH-1:0]         wr_data,
   input  logic [WIDTH-1:0]         pin_in,
   output logic [WIDTH-1:0]         pin_out,
   output logic [WIDTH-1:0]         pin_oe,
   output logic [WIDTH-1:0]         pin_pu,
   output logic [WIDTH-1:0]         port_rd,
   output logic                     key_irq
);
   localparam int NPU = WIDTH / PU_GROUP;

   if (WIDTH < 1 || PU_GROUP < 1 || (WIDTH % PU_GROUP) != 0) begin : g_bad_group
      $error("keywake_port: WIDTH must be a positive multiple of PU_GROUP");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("keywake_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] latch_q, dir_q, keyen_q, pin_sync, part_mask;
   logic [NPU-1:0]   pull_q;

   kw_regs #(.WIDTH(WIDTH), .PU_GROUP(PU_GROUP)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .keyen_q (keyen_q),
      .pull_q  (pull_q)
   );

   kw_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   always_comb part_mask = keyen_q & ~dir_q;

   kw_keydet #(.WIDTH(WIDTH)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pin_sync),
      .part  (part_mask),
      .irq   (key_irq)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pin_pu[i]  = pull_q[i / PU_GROUP];
      assign port_rd[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
   end

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/kw_checker.sv
`timescale 1ns/1ps
module kw_checker #(
   parameter int WIDTH    = 8,
   parameter int PU_GROUP = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [kw_pkg::KW_AW-1:0] wr_addr,
   input logic [WIDTH-1:0]         wr_data,
   input logic [WIDTH-1:0]         pin_oe,
   input logic [WIDTH-1:0]         pin_pu,
   input logic                     key_irq,
   input logic [WIDTH-1:0]         part
);
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      key_irq |=> !key_irq);

   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == kw_pkg::KW_DIR) |=> (pin_oe == $past(wr_data)));

   a_r5_needs_participant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_irq) |-> ($past(part) != '0));

   a_r3_group_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pu[0] == pin_pu[PU_GROUP-1]);

   a_r9_output_excluded: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe == '1) |=> !key_irq || $past(key_irq) || (part != '0) || 1'b1 == $past(part != '0));
endmodule

bind keywake_port kw_checker #(.WIDTH(WIDTH), .PU_GROUP(PU_GROUP)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .pin_oe  (pin_oe),
   .pin_pu  (pin_pu),
   .key_irq (key_irq),
   .part    (part_mask)
);

// File: tb/keywake_port_test.sv
`timescale 1ns/1ps
module keywake_port_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] pin_in = '1;
   logic [W-1:0] pin_out, pin_oe, pin_pu, port_rd;
   logic         key_irq;

   int tests = 0;
   int fails = 0;
   int irq_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   keywake_port uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pin_in  (pin_in),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .pin_pu  (pin_pu),
      .port_rd (port_rd),
      .key_irq (key_irq)
   );

   always @(negedge clk) if (rst_n && key_irq) irq_cnt++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 pin_out", pin_out, 0);
      chk("R1 pin_pu", pin_pu, 0);
      chk("R1 key_irq", key_irq, 0);
      chk("R1 port_rd", port_rd, 8'hFF);
   endtask

   task automatic t_regs;
      wr(2'd0, 8'h5A);
      chk("R2 latch", pin_out, 8'h5A);
      wr(2'd1, 8'h3C);
      chk("R2 dir", pin_oe, 8'h3C);
      wr(2'd1, 8'h00);
      chk("R2 dir clear", pin_oe, 8'h00);
   endtask

   task automatic t_pull;
      wr(2'd3, 8'h01);
      chk("R3 low group", pin_pu, 8'h0F);
      wr(2'd3, 8'h02);
      chk("R3 high group", pin_pu, 8'hF0);
      wr(2'd3, 8'hFC);
      chk("R3 upper data ignored", pin_pu, 8'h00);
      wr(2'd3, 8'h01);
   endtask

   task automatic t_readback;
      wr(2'd1, 8'hF0);
      wr(2'd0, 8'hA5);
      chk("R4 output bits from latch", port_rd, 8'hAF);
      @(negedge clk);
      pin_in = 8'h0C;
      @(negedge clk);
      chk("R4 one edge still old", port_rd, 8'hAF);
      @(negedge clk);
      chk("R4 two edges new level", port_rd, 8'hAC);
      pin_in = 8'hFF;
      idle(3);
   endtask

   task automatic t_press;
      int c0;
      wr(2'd2, 8'h0F);
      idle(3);
      c0 = irq_cnt;
      chk("R6 no request when idle", key_irq, 0);
      pin_in[0] = 1'b0;
      @(negedge clk); chk("R6 edge1 low", key_irq, 0);
      @(negedge clk); chk("R6 edge2 low", key_irq, 0);
      @(negedge clk); chk("R6 edge3 high", key_irq, 1);
      @(negedge clk); chk("R6 one cycle only", key_irq, 0);
      pin_in = 8'hFF;
      idle(4);
      chk("R6 one request per press", irq_cnt - c0, 1);
   endtask

   task automatic t_and;
      int c0;
      c0 = irq_cnt;
      pin_in[1] = 1'b0;
      idle(4);
      chk("R7 first key", irq_cnt - c0, 1);
      pin_in[2] = 1'b0;
      idle(5);
      chk("R7 second key while low", irq_cnt - c0, 1);
      pin_in = 8'hFF;
      idle(4);
      pin_in[3] = 1'b0;
      idle(4);
      chk("R7 new press after release", irq_cnt - c0, 2);
      pin_in = 8'hFF;
      idle(4);
   endtask

   task automatic t_config;
      int c0;
      c0 = irq_cnt;
      pin_in[0] = 1'b0;
      idle(4);
      chk("R8 press", irq_cnt - c0, 1);
      wr(2'd2, 8'h0E);
      idle(5);
      chk("R8 removing low pin", irq_cnt - c0, 1);
      wr(2'd2, 8'h0F);
      @(negedge clk);
      chk("R8 adding low pin", key_irq, 1);
      pin_in = 8'hFF;
      idle(4);
   endtask

   task automatic t_nonpart;
      int c0;
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h0F);
      idle(3);
      c0 = irq_cnt;
      pin_in[5] = 1'b0;
      idle(5);
      chk("R5 disabled input low", irq_cnt - c0, 0);
      pin_in = 8'hFF;
      idle(3);
      wr(2'd0, 8'h10);
      wr(2'd1, 8'h10);
      wr(2'd2, 8'h1F);
      idle(3);
      c0 = irq_cnt;
      pin_in[4] = 1'b0;
      idle(5);
      chk("R9 output pin low", irq_cnt - c0, 0);
      chk("R9 output pin reads latch", port_rd[4], 1);
      pin_in = 8'hFF;
      idle(3);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      t_reset;
      rst_n = 1'b1;
      idle(2);
      t_reset;
      t_regs;
      t_pull;
      t_readback;
      t_press;
      t_and;
      t_config;
      t_nonpart;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule